// File: doc/BRIEF.md
# Raster Sync and Blanking Timing Generator

This block generates the timing for a low-resolution raster display that runs from a 12 MHz pixel clock. A column counter advances on every clock. A row counter advances once each time the column counter completes a line. Both counter values are brought out so that downstream address logic can use them.

The block compares the counters against fixed positions and forms two active-low sync strobes. The horizontal strobe is re-evaluated on every clock. The vertical strobe is re-evaluated only at the end of a line. The sync edges sit a little early so that they absorb the two clocks of latency in the pixel fetch and colour path. The block also produces a blank flag that covers everything outside the 256 x 480 visible area. It gives this flag in two forms: combinational, and delayed by one register so that it lines up with the colour stage.

With the default parameters a line lasts 381 clocks (31.75 µs) and a frame lasts 528 lines.

Top module: `vga_timing`

## Requirements
- R1: The column counter `pix_cnt` counts 0, 1, ..., H_TOTAL-1 (380 by default) on successive clocks and then returns to 0.
- R2: The row counter `line_cnt` holds its value except on the clock where `pix_cnt` leaves H_TOTAL-1. On that clock it increments, or returns to 0 if it was V_TOTAL-1 (527).
- R3: `hsync_n` is low exactly while `pix_cnt` is in 292..337. It falls on the clock after the column count was 291 and rises on the clock after it was 337, giving 46 clocks low.
- R4: `vsync_n` is low exactly while `line_cnt` is 494 or 495, giving two lines low. It changes only on the clock where a line completes.
- R5: `blank` is 1 whenever `pix_cnt` >= 256 or `line_cnt` >= 480, and 0 otherwise, within the same cycle.
- R6: `blank_q` equals the value `blank` had one clock earlier.
- R7: While `rst` is high, both counters read 0, `hsync_n` and `vsync_n` read 1, and `blank_q` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Asynchronous reset, active high |
| pix_cnt | output | PX_W (9) | Column position within the line |
| line_cnt | output | LN_W (10) | Row position within the frame |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | Combinational blank flag |
| blank_q | output | 1 | Blank flag delayed by one clock |

## Verification
The hardest behaviour to reach is the vertical strobe, because the rows near 494 occur only after roughly 188,000 clocks. The hardest of all is the row wrap from 527 back to 0, which lies beyond the cycle budget of one run. The bench therefore lets the default instance run from reset through line 496 and compares every output on every clock with an independent model. A second instance with a tiny line and frame size shares the same clock and shows the row counter wrapping, together with the sync windows on both ends of the frame.

// File: rtl/vga_timing_pkg.sv
package vga_timing_pkg;

  // Last count before a counter of length 'total' wraps.
  function automatic logic is_last(input int unsigned cnt, input int unsigned total);
    return cnt == total - 1;
  endfunction

  // Outside the visible rectangle?
  function automatic logic outside_view(input int unsigned px, input int unsigned ln,
                                        input int unsigned h_vis, input int unsigned v_vis);
    return (px >= h_vis) || (ln >= v_vis);
  endfunction

endpackage

// File: rtl/wrap_counter.sv
module wrap_counter #(
  parameter int unsigned TOTAL = 381,
  parameter int unsigned W     = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         at_last
);
  import vga_timing_pkg::*;

  assign at_last = is_last(int'(cnt), TOTAL);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          cnt <= '0;
    else if (en) begin
      if (at_last)    cnt <= '0;
      else            cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sync_pulse.sv
module sync_pulse (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic go_low,
  input  logic go_high,
  output logic q_n
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)          q_n <= 1'b1;
    else if (en) begin
      if (go_low)     q_n <= 1'b0;
      else if (go_high) q_n <= 1'b1;
    end
  end
endmodule

// File: rtl/blank_stage.sv
module blank_stage (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/vga_timing.sv
module vga_timing #(
  parameter int unsigned H_TOTAL  = 381,
  parameter int unsigned V_TOTAL  = 528,
  parameter int unsigned H_VIS    = 256,
  parameter int unsigned V_VIS    = 480,
  parameter int unsigned HS_FROM  = 291,
  parameter int unsigned HS_TO    = 337,
  parameter int unsigned VS_FROM  = 493,
  parameter int unsigned VS_TO    = 495,
  parameter int unsigned PX_W     = $clog2(H_TOTAL),
  parameter int unsigned LN_W     = $clog2(V_TOTAL)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PX_W-1:0] pix_cnt,
  output logic [LN_W-1:0] line_cnt,
  output logic            hsync_n,
  output logic            vsync_n,
  output logic            blank,
  output logic            blank_q
);
  import vga_timing_pkg::*;

  // Named internal events, also observed by the checker.
  logic line_end;
  logic frame_last;
  logic hs_fall, hs_rise, vs_fall, vs_rise;

  wrap_counter #(.TOTAL(H_TOTAL), .W(PX_W)) u_pix (
    .clk(clk), .rst(rst), .en(1'b1), .cnt(pix_cnt), .at_last(line_end)
  );

  wrap_counter #(.TOTAL(V_TOTAL), .W(LN_W)) u_line (
    .clk(clk), .rst(rst), .en(line_end), .cnt(line_cnt), .at_last(frame_last)
  );

  assign hs_fall = (int'(pix_cnt)  == HS_FROM);
  assign hs_rise = (int'(pix_cnt)  == HS_TO);
  assign vs_fall = (int'(line_cnt) == VS_FROM);
  assign vs_rise = (int'(line_cnt) == VS_TO);

  sync_pulse u_hs (
    .clk(clk), .rst(rst), .en(1'b1), .go_low(hs_fall), .go_high(hs_rise), .q_n(hsync_n)
  );

  sync_pulse u_vs (
    .clk(clk), .rst(rst), .en(line_end), .go_low(vs_fall), .go_high(vs_rise), .q_n(vsync_n)
  );

  assign blank = outside_view(int'(pix_cnt), int'(line_cnt), H_VIS, V_VIS);

  blank_stage u_blank (.clk(clk), .rst(rst), .d(blank), .q(blank_q));
endmodule

// File: rtl/vga_timing_chk.sv
module vga_timing_chk #(
  parameter int unsigned H_TOTAL = 381,
  parameter int unsigned V_TOTAL = 528,
  parameter int unsigned HS_FROM = 291,
  parameter int unsigned HS_TO   = 337,
  parameter int unsigned PX_W    = 9,
  parameter int unsigned LN_W    = 10
) (
  input logic            clk,
  input logic            rst,
  input logic [PX_W-1:0] pix,
  input logic [LN_W-1:0] line,
  input logic            hsync_n,
  input logic            vsync_n,
  input logic            blank,
  input logic            blank_q,
  input logic            line_end
);
  a_r1_pix_range: assert property (@(posedge clk) disable iff (rst) int'(pix) < H_TOTAL);
  a_r1_pix_wrap:  assert property (@(posedge clk) disable iff (rst)
                    int'(pix) == H_TOTAL - 1 |=> pix == '0);
  a_r2_line_hold: assert property (@(posedge clk) disable iff (rst)
                    !line_end |=> $stable(line));
  a_r2_line_range: assert property (@(posedge clk) disable iff (rst) int'(line) < V_TOTAL);
  a_r3_hs_fall:   assert property (@(posedge clk) disable iff (rst)
                    int'(pix) == HS_FROM |=> !hsync_n);
  a_r3_hs_rise:   assert property (@(posedge clk) disable iff (rst)
                    int'(pix) == HS_TO |=> hsync_n);
  a_r4_vs_hold:   assert property (@(posedge clk) disable iff (rst)
                    !line_end |=> $stable(vsync_n));
  a_r6_blank_dly: assert property (@(posedge clk) disable iff (rst)
                    1'b1 |=> blank_q == $past(blank));
endmodule

bind vga_timing vga_timing_chk #(
  .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HS_FROM(HS_FROM), .HS_TO(HS_TO),
  .PX_W(PX_W), .LN_W(LN_W)
) u_chk (
  .clk(clk), .rst(rst), .pix(pix_cnt), .line(line_cnt), .hsync_n(hsync_n),
  .vsync_n(vsync_n), .blank(blank), .blank_q(blank_q), .line_end(line_end)
);

// File: tb/vga_timing_tb.sv
module vga_timing_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 199500;

  // Default geometry, restated for the model.
  localparam int HT = 381, VT = 528, HV = 256, VV = 480;
  localparam int HSA = 291, HSB = 337, VSA = 493, VSB = 495;
  // Tiny geometry for the wrap test.
  localparam int SHT = 8, SVT = 6, SHV = 4, SVV = 3;
  localparam int SHSA = 4, SHSB = 6, SVSA = 3, SVSB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [8:0] pix;  logic [9:0] line;
  logic hs, vs, bl, blq;
  logic [2:0] s_pix; logic [2:0] s_line;
  logic s_hs, s_vs, s_bl, s_blq;

  vga_timing u_dut (
    .clk(clk), .rst(rst), .pix_cnt(pix), .line_cnt(line),
    .hsync_n(hs), .vsync_n(vs), .blank(bl), .blank_q(blq)
  );

  vga_timing #(
    .H_TOTAL(SHT), .V_TOTAL(SVT), .H_VIS(SHV), .V_VIS(SVV),
    .HS_FROM(SHSA), .HS_TO(SHSB), .VS_FROM(SVSA), .VS_TO(SVSB)
  ) u_small (
    .clk(clk), .rst(rst), .pix_cnt(s_pix), .line_cnt(s_line),
    .hsync_n(s_hs), .vsync_n(s_vs), .blank(s_bl), .blank_q(s_blq)
  );

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  // Model state.
  int ep, el; bit eprev;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (px %0d ln %0d)", tag, act, exp, ep, el);
    end
  endtask

  // Sync low strictly after 'a' up to and including 'b'.
  function automatic int low_win(input int c, input int a, input int b);
    return (c > a && c <= b) ? 0 : 1;
  endfunction

  task automatic step_model(input int ht, input int vt, input int hv, input int vv);
    eprev = (ep >= hv) || (el >= vv);
    @(posedge clk); @(negedge clk);
    cycles++;
    if (ep == ht - 1) begin
      ep = 0;
      el = (el == vt - 1) ? 0 : el + 1;
    end else ep++;
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 pix", int'(pix), 0);    chk("R7 line", int'(line), 0);
    chk("R7 hsync", int'(hs), 1);   chk("R7 vsync", int'(vs), 1);
    chk("R7 blank_q", int'(blq), 0);
    rst = 1'b0;
    ep = 0; el = 0; eprev = 0;
  endtask

  // Small instance: two full frames covering both wraps (R1, R2).
  task automatic t_small_wrap;
    do_reset();
    for (int i = 0; i < 2*SHT*SVT + 3; i++) begin
      step_model(SHT, SVT, SHV, SVV);
      chk("R1 small pix", int'(s_pix), ep);
      chk("R2 small line wrap", int'(s_line), el);
      chk("R3 small hsync", int'(s_hs), low_win(ep, SHSA, SHSB));
      chk("R4 small vsync", int'(s_vs), low_win(el, SVSA, SVSB));
      chk("R5 small blank", int'(s_bl), ((ep >= SHV) || (el >= SVV)) ? 1 : 0);
      chk("R6 small blank_q", int'(s_blq), int'(eprev));
    end
  endtask

  // Default instance: run through the vertical sync window.
  task automatic t_frame_to_vsync;
    do_reset();
    while (!(el == VSB + 1 && ep == 5)) begin
      step_model(HT, VT, HV, VV);
      chk("R1 pix", int'(pix), ep);
      chk("R2 line", int'(line), el);
      chk("R3 hsync", int'(hs), low_win(ep, HSA, HSB));
      chk("R4 vsync", int'(vs), low_win(el, VSA, VSB));
      chk("R5 blank", int'(bl), ((ep >= HV) || (el >= VV)) ? 1 : 0);
      chk("R6 blank_q", int'(blq), int'(eprev));
    end
  endtask

  initial begin
    t_small_wrap();
    t_frame_to_vsync();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    while (cycles < WATCHDOG && !done) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule